// File: doc/BRIEF.md
# Stereo attenuation combine and update

This block keeps the playback level settings for an eight-channel DAC codec and turns every change into codec register writes. Each channel has a 7-bit volume and a mute flag. Two master sides, left and right, each have an 8-bit volume and a mute flag. When neither mute applies, the channel volume and its side's master volume are multiplied and scaled, and the result indexes a logarithmic table. The entry read from the table gives the attenuation code that is sent to the codec. A separate digital master level is mapped to its own register.

The host writes settings through a simple write strobe. Any write that changes a stored value marks the affected codec registers as pending. A scheduler drains the pending registers one at a time over a request/acknowledge port to the serial link. Each register goes out as a pair of writes: a prelatch write and then an update write that carries the latch bits. The code is computed at the moment the scheduler picks the register, so a burst of changes to one channel collapses into the latest value.

Top module: `stereo_att_ctrl`

## Requirements
- R1: After reset no write is requested. All channel and master mute flags are set, and all volumes and the digital level are 0.
- R2: A channel whose own mute flag or whose side's master mute flag is set gets attenuation code 0.
- R3: For an unmuted channel, idx = (channel volume * master volume) / 127, kept to 8 bits. The table T(0) = 127, and T(x) = round(20*log10(255/x)) for x > 0. The code is 127 - T(idx).
- R4: Channel n (0..7) is written at codec address n. The first write carries the code in data bits [6:0] with bits 8 and 7 clear. The second write carries code | 0x180.
- R5: Even channels combine with the left master (volume at host address 0x10, mute at 0x12). Odd channels combine with the right master (volume at 0x11, mute at 0x13).
- R6: A change of a master volume or master mute rewrites every channel of that side.
- R7: A host write of a value above 0x7F to a channel volume (host addresses 0x00..0x07) is ignored. A valid volume write leaves the channel mute flag (bit 0 at host addresses 0x08..0x0F) as it is.
- R8: The digital master level (host address 0x14) accepts 0..128, and larger values are ignored. Level 0 gives code 0 and level v gives v + 127. The code is written to codec address 0x11, first plain and then with bit 8 set.
- R9: A host write that leaves the stored value unchanged, or that targets an unused host address, causes no codec write.
- R10: Pending registers go out one at a time. The request is held with stable address and data until it is acknowledged. The order is even channels ascending, then odd channels ascending, then the digital master. A change made while a register is in flight is sent again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Host write strobe |
| cfg_addr_i | input | 5 | Host setting address |
| cfg_wdata_i | input | 8 | Host write data |
| wr_req_o | output | 1 | Codec write request |
| wr_addr_o | output | 7 | Codec register address |
| wr_data_o | output | 9 | Codec register data |
| wr_ack_i | input | 1 | Codec write accepted |

## Verification
Directed steps walk the combine path through five cases: fully muted, master muted only, zero channel volume, full-scale product (code 127) and a mid product (code 121). These separate the mute gating from the table lookup and from the index scaling. Out-of-range volumes and levels, repeated identical values and an unused address are followed by a master change, so the bench can confirm from the emitted codes that nothing was stored. A burst made while the acknowledge is withheld, which includes a second change to the channel already in flight, pins down the drain order and the re-send. Seeded random writes over the whole host map, with a randomly delayed acknowledge, are then compared word for word against a bench model that uses a floating-point log table.

// File: rtl/stereo_att_pkg.sv
package stereo_att_pkg;

  localparam int LOG_IW = 8;
  localparam int LOG_STEPS = 48;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_UPD} wr_state_e;

  // largest index whose rounded dB value reaches k
  function automatic int log_thr(input int k);
    case (k)
      1: return 240;  2: return 214;  3: return 191;  4: return 170;
      5: return 151;  6: return 135;  7: return 120;  8: return 107;
      9: return 95;   10: return 85;  11: return 76;  12: return 67;
      13: return 60;  14: return 53;  15: return 48;  16: return 42;
      17: return 38;  18: return 34;  19: return 30;  20: return 27;
      21: return 24;  22: return 21;  23: return 19;  24: return 17;
      25: return 15;  26: return 13;  27: return 12;  28: return 10;
      29: return 9;   30: return 8;   31: return 7;   32: return 6;
      33: return 6;   34: return 5;   35: return 4;   36: return 4;
      37: return 3;   38: return 3;   39: return 3;   40: return 2;
      41: return 2;   42: return 2;   43: return 1;   44: return 1;
      45: return 1;   46: return 1;   47: return 1;   48: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [6:0] log_att(input int x);
    int n;
    n = 0;
    if (x == 0) return 7'd127;
    for (int k = 1; k <= LOG_STEPS; k++)
      if (x <= log_thr(k)) n++;
    return 7'(n);
  endfunction

endpackage

// File: rtl/stereo_att_rom.sv
module stereo_att_rom
  import stereo_att_pkg::*;
(
  input  logic [LOG_IW-1:0] idx_i,
  output logic [6:0]        att_o
);
  localparam int DEPTH = 2 ** LOG_IW;

  logic [6:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = log_att(i);
  end

  assign att_o = rom[idx_i];
endmodule

// File: rtl/stereo_att_calc.sv
module stereo_att_calc
  import stereo_att_pkg::*;
#(
  parameter int VW = 7,
  parameter int MW = 8
) (
  input  logic [VW-1:0] ch_vol_i,
  input  logic [MW-1:0] m_vol_i,
  input  logic          mute_i,
  output logic [VW-1:0] code_o
);
  localparam int PW = VW + MW;
  localparam int VOL_MAX = 2 ** VW - 1;

  logic [PW-1:0]     prod;
  logic [LOG_IW-1:0] idx;
  logic [6:0]        att;

  assign prod = PW'(ch_vol_i) * PW'(m_vol_i);
  assign idx  = LOG_IW'(prod / PW'(VOL_MAX));

  stereo_att_rom u_rom (
    .idx_i (idx),
    .att_o (att)
  );

  assign code_o = mute_i ? '0 : VW'(VOL_MAX) - VW'(att);
endmodule

// File: rtl/stereo_att_regs.sv
module stereo_att_regs #(
  parameter int NUM_CH  = 8,
  parameter int VW      = 7,
  parameter int MW      = 8,
  parameter int DW      = 8,
  parameter int AW      = 5,
  parameter int DIG_MAX = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [NUM_CH-1:0]          clr_ch_i,
  input  logic                       clr_dig_i,
  output logic [NUM_CH-1:0][VW-1:0]  ch_vol_o,
  output logic [NUM_CH-1:0]          ch_mute_o,
  output logic [1:0][MW-1:0]         m_vol_o,
  output logic [1:0]                 m_mute_o,
  output logic [DW-1:0]              dig_lvl_o,
  output logic [NUM_CH-1:0]          dirty_ch_o,
  output logic                       dirty_dig_o
);
  localparam int A_MUTE  = NUM_CH;
  localparam int A_MVOL  = 2 * NUM_CH;
  localparam int A_MMUTE = A_MVOL + 2;
  localparam int A_DIG   = A_MMUTE + 2;
  localparam int VOL_MAX = 2 ** VW - 1;

  logic [NUM_CH-1:0][VW-1:0] vol_d;
  logic [NUM_CH-1:0]         mute_d, set_ch;
  logic [1:0][MW-1:0]        mvol_d;
  logic [1:0]                mmute_d;
  logic [DW-1:0]             dig_d;
  logic                      set_dig;

  always_comb begin
    vol_d   = ch_vol_o;
    mute_d  = ch_mute_o;
    mvol_d  = m_vol_o;
    mmute_d = m_mute_o;
    dig_d   = dig_lvl_o;
    set_ch  = '0;
    set_dig = 1'b0;
    if (we_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == AW'(i) && wdata_i <= DW'(VOL_MAX) &&
            wdata_i[VW-1:0] != ch_vol_o[i]) begin
          vol_d[i]  = wdata_i[VW-1:0];
          set_ch[i] = 1'b1;
        end
        if (addr_i == AW'(A_MUTE + i) && wdata_i[0] != ch_mute_o[i]) begin
          mute_d[i] = wdata_i[0];
          set_ch[i] = 1'b1;
        end
      end
      for (int s = 0; s < 2; s++) begin
        if ((addr_i == AW'(A_MVOL + s) && wdata_i[MW-1:0] != m_vol_o[s]) ||
            (addr_i == AW'(A_MMUTE + s) && wdata_i[0] != m_mute_o[s])) begin
          if (addr_i == AW'(A_MVOL + s)) mvol_d[s] = wdata_i[MW-1:0];
          else                           mmute_d[s] = wdata_i[0];
          for (int c = s; c < NUM_CH; c += 2) set_ch[c] = 1'b1;
        end
      end
      if (addr_i == AW'(A_DIG) && wdata_i <= DW'(DIG_MAX) && wdata_i != dig_lvl_o) begin
        dig_d   = wdata_i;
        set_dig = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_vol_o    <= '0;
      ch_mute_o   <= '1;
      m_vol_o     <= '0;
      m_mute_o    <= '1;
      dig_lvl_o   <= '0;
      dirty_ch_o  <= '0;
      dirty_dig_o <= 1'b0;
    end else begin
      ch_vol_o    <= vol_d;
      ch_mute_o   <= mute_d;
      m_vol_o     <= mvol_d;
      m_mute_o    <= mmute_d;
      dig_lvl_o   <= dig_d;
      // a fresh change wins over the scheduler's clear
      dirty_ch_o  <= (dirty_ch_o & ~clr_ch_i) | set_ch;
      dirty_dig_o <= (dirty_dig_o & ~clr_dig_i) | set_dig;
    end
  end
endmodule

// File: rtl/stereo_att_sched.sv
module stereo_att_sched
  import stereo_att_pkg::*;
#(
  parameter int                 NUM_CH   = 8,
  parameter int                 VW       = 7,
  parameter int                 MW       = 8,
  parameter int                 DW       = 8,
  parameter int                 CAW      = 7,
  parameter int                 CDW      = 9,
  parameter logic [CAW-1:0]     DIG_ADDR = 7'h11
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0][VW-1:0]  ch_vol_i,
  input  logic [NUM_CH-1:0]          ch_mute_i,
  input  logic [1:0][MW-1:0]         m_vol_i,
  input  logic [1:0]                 m_mute_i,
  input  logic [DW-1:0]              dig_lvl_i,
  input  logic [NUM_CH-1:0]          dirty_ch_i,
  input  logic                       dirty_dig_i,
  output logic [NUM_CH-1:0]          clr_ch_o,
  output logic                       clr_dig_o,
  output logic                       req_o,
  output logic [CAW-1:0]             addr_o,
  output logic [CDW-1:0]             data_o,
  input  logic                       ack_i
);
  localparam int HALF = NUM_CH / 2;
  localparam int CW   = $clog2(NUM_CH);
  localparam logic [CDW-1:0] UPD_CH  = {2'b11, {(CDW-2){1'b0}}};
  localparam logic [CDW-1:0] UPD_DIG = {1'b1, {(CDW-1){1'b0}}};
  localparam int DIG_OFS = 2 ** VW - 1;

  wr_state_e      state_q;
  logic [CAW-1:0] addr_q;
  logic [CDW-1:0] data_q;
  logic           dig_q;

  logic           found, sel_dig;
  logic [CW-1:0]  sel_ch;
  logic [VW-1:0]  ch_code;
  logic [DW-1:0]  dig_code;

  // evens ascending, odds ascending, digital master last
  always_comb begin
    found   = 1'b0;
    sel_dig = 1'b0;
    sel_ch  = '0;
    for (int j = 0; j < NUM_CH; j++) begin
      int c;
      c = (j < HALF) ? 2 * j : 2 * (j - HALF) + 1;
      if (!found && dirty_ch_i[c]) begin
        found  = 1'b1;
        sel_ch = CW'(c);
      end
    end
    if (!found && dirty_dig_i) begin
      found   = 1'b1;
      sel_dig = 1'b1;
    end
  end

  stereo_att_calc #(.VW(VW), .MW(MW)) u_calc (
    .ch_vol_i (ch_vol_i[sel_ch]),
    .m_vol_i  (m_vol_i[sel_ch[0]]),
    .mute_i   (ch_mute_i[sel_ch] | m_mute_i[sel_ch[0]]),
    .code_o   (ch_code)
  );

  assign dig_code = (dig_lvl_i == '0) ? '0 : dig_lvl_i + DW'(DIG_OFS);

  always_comb begin
    clr_ch_o  = '0;
    clr_dig_o = 1'b0;
    if (state_q == ST_IDLE && found) begin
      if (sel_dig) clr_dig_o = 1'b1;
      else         clr_ch_o[sel_ch] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      dig_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (found) begin
          state_q <= ST_PRE;
          dig_q   <= sel_dig;
          if (sel_dig) begin
            addr_q <= DIG_ADDR;
            data_q <= CDW'(dig_code);
          end else begin
            addr_q <= CAW'(sel_ch);
            data_q <= CDW'(ch_code);
          end
        end
        ST_PRE: if (ack_i) begin
          state_q <= ST_UPD;
          data_q  <= data_q | (dig_q ? UPD_DIG : UPD_CH);
        end
        ST_UPD: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q != ST_IDLE);
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/stereo_att_ctrl.sv
module stereo_att_ctrl #(
  parameter int             NUM_CH   = 8,
  parameter int             VW       = 7,
  parameter int             MW       = 8,
  parameter int             DW       = 8,
  parameter int             AW       = 5,
  parameter int             CAW      = 7,
  parameter int             CDW      = 9,
  parameter logic [CAW-1:0] DIG_ADDR = 7'h11,
  parameter int             DIG_MAX  = 128
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [AW-1:0]  cfg_addr_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic           wr_req_o,
  output logic [CAW-1:0] wr_addr_o,
  output logic [CDW-1:0] wr_data_o,
  input  logic           wr_ack_i
);
  logic [NUM_CH-1:0][VW-1:0] ch_vol;
  logic [NUM_CH-1:0]         ch_mute, dirty_ch, clr_ch;
  logic [1:0][MW-1:0]        m_vol;
  logic [1:0]                m_mute;
  logic [DW-1:0]             dig_lvl;
  logic                      dirty_dig, clr_dig;

  stereo_att_regs #(
    .NUM_CH(NUM_CH), .VW(VW), .MW(MW), .DW(DW), .AW(AW), .DIG_MAX(DIG_MAX)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .clr_ch_i    (clr_ch),
    .clr_dig_i   (clr_dig),
    .ch_vol_o    (ch_vol),
    .ch_mute_o   (ch_mute),
    .m_vol_o     (m_vol),
    .m_mute_o    (m_mute),
    .dig_lvl_o   (dig_lvl),
    .dirty_ch_o  (dirty_ch),
    .dirty_dig_o (dirty_dig)
  );

  stereo_att_sched #(
    .NUM_CH(NUM_CH), .VW(VW), .MW(MW), .DW(DW),
    .CAW(CAW), .CDW(CDW), .DIG_ADDR(DIG_ADDR)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ch_vol_i    (ch_vol),
    .ch_mute_i   (ch_mute),
    .m_vol_i     (m_vol),
    .m_mute_i    (m_mute),
    .dig_lvl_i   (dig_lvl),
    .dirty_ch_i  (dirty_ch),
    .dirty_dig_i (dirty_dig),
    .clr_ch_o    (clr_ch),
    .clr_dig_o   (clr_dig),
    .req_o       (wr_req_o),
    .addr_o      (wr_addr_o),
    .data_o      (wr_data_o),
    .ack_i       (wr_ack_i)
  );
endmodule

// File: rtl/stereo_att_chk.sv
module stereo_att_chk #(
  parameter int             NUM_CH   = 8,
  parameter int             CAW      = 7,
  parameter int             CDW      = 9,
  parameter logic [CAW-1:0] DIG_ADDR = 7'h11
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_req_o,
  input logic           wr_ack_i,
  input logic [CAW-1:0] wr_addr_o,
  input logic [CDW-1:0] wr_data_o
);
  localparam logic [CDW-1:0] UPD_CH  = {2'b11, {(CDW-2){1'b0}}};
  localparam logic [CDW-1:0] UPD_DIG = {1'b1, {(CDW-1){1'b0}}};

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_gap_after_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i && wr_data_o[CDW-1] |=> !wr_req_o);

  assert_addr_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_addr_o < CAW'(NUM_CH)) || (wr_addr_o == DIG_ADDR));

  assert_latch_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i && wr_addr_o < CAW'(NUM_CH) && wr_data_o[CDW-1:CDW-2] == 2'b00
    |=> wr_req_o && wr_addr_o == $past(wr_addr_o) && wr_data_o == ($past(wr_data_o) | UPD_CH));

  assert_code_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_addr_o < CAW'(NUM_CH) |-> wr_data_o[CDW-1] == wr_data_o[CDW-2]);

  assert_dig_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i && wr_addr_o == DIG_ADDR && !wr_data_o[CDW-1]
    |=> wr_req_o && wr_addr_o == DIG_ADDR && wr_data_o == ($past(wr_data_o) | UPD_DIG));

  assert_dig_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_addr_o == DIG_ADDR && !wr_data_o[CDW-1]
    |-> wr_data_o[CDW-2:0] == '0 || wr_data_o[CDW-2]);
endmodule

bind stereo_att_ctrl stereo_att_chk #(
  .NUM_CH(NUM_CH), .CAW(CAW), .CDW(CDW), .DIG_ADDR(DIG_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_req_o  (wr_req_o),
  .wr_ack_i  (wr_ack_i),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/tb_stereo_att_ctrl.sv
module tb_stereo_att_ctrl;
  logic       clk, rst_n, we, ack;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic       req;
  logic [6:0] waddr;
  logic [8:0] wdat;

  int checks = 0, errors = 0;
  int exp_a [128], exp_d [128], exp_n = 0;
  int rec_a [128], rec_d [128], rec_n = 0;
  bit hold = 0;
  bit done = 0;

  // bench shadow of the host settings
  int v [8], cm [8], mv [2], mm [2], dig;

  stereo_att_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .wr_req_o(req), .wr_addr_o(waddr),
    .wr_data_o(wdat), .wr_ack_i(ack)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int tbl(input int x);
    if (x == 0) return 127;
    return int'(20.0 * $log10(255.0 / real'(x)));
  endfunction

  function automatic int exp_code(input int ch);
    int idx;
    if (cm[ch] != 0 || mm[ch % 2] != 0) return 0;
    idx = ((v[ch] * mv[ch % 2]) / 127) & 255;
    return 127 - tbl(idx);
  endfunction

  task automatic push_ch(input int ch);
    exp_a[exp_n] = ch; exp_d[exp_n] = exp_code(ch); exp_n++;
    exp_a[exp_n] = ch; exp_d[exp_n] = exp_code(ch) | 'h180; exp_n++;
  endtask

  task automatic push_dig();
    int c;
    c = (dig == 0) ? 0 : dig + 127;
    exp_a[exp_n] = 'h11; exp_d[exp_n] = c; exp_n++;
    exp_a[exp_n] = 'h11; exp_d[exp_n] = c | 'h100; exp_n++;
  endtask

  task automatic mdl_write(input int a, input int d, input bit push);
    if (a < 8) begin
      if (d <= 127 && d != v[a]) begin v[a] = d; if (push) push_ch(a); end
    end else if (a < 16) begin
      if ((d & 1) != cm[a - 8]) begin cm[a - 8] = d & 1; if (push) push_ch(a - 8); end
    end else if (a < 18) begin
      if ((d & 255) != mv[a - 16]) begin
        mv[a - 16] = d & 255;
        if (push) for (int c = a - 16; c < 8; c += 2) push_ch(c);
      end
    end else if (a < 20) begin
      if ((d & 1) != mm[a - 18]) begin
        mm[a - 18] = d & 1;
        if (push) for (int c = a - 18; c < 8; c += 2) push_ch(c);
      end
    end else if (a == 20) begin
      if (d <= 128 && d != dig) begin dig = d; if (push) push_dig(); end
    end
  endtask

  task automatic host_wr(input int a, input int d);
    @(negedge clk);
    we = 1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic op(input int a, input int d);
    host_wr(a, d);
    mdl_write(a, d, 1'b1);
  endtask

  // codec side: records each accepted word, randomly delays acknowledge
  initial begin
    ack = 0;
    forever begin
      @(negedge clk);
      if (ack) ack = 0;
      else if (req && !hold && ($urandom % 4 != 0)) begin
        if (rec_n < 128) begin rec_a[rec_n] = int'(waddr); rec_d[rec_n] = int'(wdat); end
        rec_n++;
        ack = 1;
      end
    end
  end

  task automatic settle();
    int quiet;
    quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      if (req) quiet = 0; else quiet++;
    end
  endtask

  task automatic compare(input string tag);
    settle();
    checks++;
    if (rec_n != exp_n) begin
      errors++;
      $display("FAIL %s: write count actual %0d expected %0d", tag, rec_n, exp_n);
    end
    for (int i = 0; i < exp_n && i < rec_n && i < 128; i++) begin
      checks++;
      if (rec_a[i] != exp_a[i] || rec_d[i] != exp_d[i]) begin
        errors++;
        $display("FAIL %s: word %0d actual addr %0h data %0h expected addr %0h data %0h",
                 tag, i, rec_a[i], rec_d[i], exp_a[i], exp_d[i]);
      end
    end
    rec_n = 0;
    exp_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    we = 0; addr = 0; wdata = 0; rst_n = 0;
    for (int i = 0; i < 8; i++) begin v[i] = 0; cm[i] = 1; end
    mv[0] = 0; mv[1] = 0; mm[0] = 1; mm[1] = 1; dig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: idle after reset
    checks++;
    if (req !== 1'b0) begin
      errors++;
      $display("FAIL R1: req actual %0b expected 0", req);
    end
    compare("R1");

    // R2: left master unmuted, channel mutes still set -> code 0
    op('h12, 0);               compare("R2");
    // R6: master volume rewrites whole left side
    op('h10, 255);             compare("R6");
    op('h08, 0);               compare("R3 zero volume");
    op('h00, 127);             compare("R3 full scale");
    op('h00, 64);              compare("R3 mid");
    // R9: same value again, unused address
    op('h00, 64);              compare("R9 repeat");
    op('h15, 33);              compare("R9 unused address");
    // R7: out-of-range volume ignored, seen through the next master change
    op('h00, 200);             compare("R7 ignored");
    op('h10, 254);             compare("R7 stored value kept");
    op('h08, 1);               compare("R2 channel mute");
    op('h00, 100);             compare("R7 mute kept on volume write");
    op('h08, 0);               compare("R3 unmute");
    // R5: odd channel follows the right master
    op('h13, 0);               compare("R5 right unmute");
    op('h11, 200);             compare("R5 right volume");
    op('h09, 0);               compare("R5 odd unmute");
    op('h01, 90);              compare("R5 odd volume");
    op('h0A, 0);               compare("R5 even unmute");
    op('h02, 90);              compare("R5 even volume");
    op('h0D, 0);               compare("R2 unmute ch5");
    op('h0E, 0);               compare("R2 unmute ch6");
    op('h12, 1);               compare("R2 left master mute");
    op('h12, 0);               compare("R6 left master unmute");
    // R8: digital master level
    op('h14, 0);               compare("R9 digital unchanged");
    op('h14, 128);             compare("R8 top level");
    op('h14, 1);               compare("R8 low level");
    op('h14, 129);             compare("R8 ignored");
    op('h14, 0);               compare("R8 zero");

    // R10: burst while acknowledge is withheld
    hold = 1;
    host_wr('h05, 10); mdl_write('h05, 10, 1'b0); push_ch(5);
    host_wr('h05, 20); mdl_write('h05, 20, 1'b0);
    host_wr('h02, 33); mdl_write('h02, 33, 1'b0);
    host_wr('h06, 77); mdl_write('h06, 77, 1'b0);
    host_wr('h01, 5);  mdl_write('h01, 5, 1'b0);
    host_wr('h14, 50); mdl_write('h14, 50, 1'b0);
    push_ch(2); push_ch(6); push_ch(1); push_ch(5); push_dig();
    repeat (5) @(negedge clk);
    checks++;
    if (req !== 1'b1 || waddr !== 7'd5 || rec_n != 0) begin
      errors++;
      $display("FAIL R10: held req %0b addr %0d recorded %0d expected 1 5 0", req, waddr, rec_n);
    end
    hold = 0;
    compare("R10 order");

    // random writes over the host map
    for (int n = 0; n < 70; n++) begin
      int a, d;
      a = int'($urandom % 22);
      if (a < 8)       d = int'($urandom % 160);
      else if (a < 16) d = int'($urandom % 2);
      else if (a < 18) d = int'($urandom % 256);
      else if (a < 20) d = int'($urandom % 2);
      else             d = int'($urandom % 140);
      op(a, d);
      compare("R3 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule